// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block watches a bank of already-synchronized general-purpose input pins and turns selected pin activity into interrupt events. Each line can detect a rising edge, a falling edge, a high level and a low level. Any mix of these can be enabled on a line at the same time. A detected event sets that line's bit in an event status register. Software clears a status bit by writing a 1 to it.

Two per-line masks reduce the status word to two outputs. One mask drives the bank interrupt request. The other drives a separate wakeup request.

A single synchronous register port configures the block. On a clock edge where the write strobe is high, the port updates the register selected by a 3-bit word offset. Read data is a combinational function of the offset and the current register contents.

Edge-sourced status bits stay latched until they are cleared. Level-sourced status bits are set again on every cycle the level holds. A clear therefore only removes a level-sourced bit once the pin has left its active level.

Top module: `gpio_evt_top`

## Requirements
- R1: A line with its rising enable set (offset 5, bit = line) gets its status bit set on the first clock edge at which the pin reads 1 and read 0 at the previous edge. The bit is visible in status (offset 0) right after that edge. A rising edge on a line whose rising enable is clear sets nothing.
- R2: A line with its falling enable set (offset 6) gets its status bit set when the pin goes from 1 to 0. With both the rising and falling enables set, either edge sets the bit.
- R3: A line with level-high enable (offset 4) or level-low enable (offset 3) gets its status bit set on every edge at which the pin is at the enabled level. A clear written while that level holds leaves the bit set.
- R4: A status bit, once set, stays set until a write to offset 0 with a 1 in that bit position. This holds even after the pin has left the level or edge that set it. Zero bits in such a write leave their status bits unchanged.
- R5: If a clear write to a status bit and a new event on that bit fall on the same clock edge, the bit is set after that edge.
- R6: irqOut is 1 exactly when some line has both its status bit and its interrupt enable bit (offset 1) set.
- R7: wakeOut is 1 exactly when some line has both its status bit and its wakeup enable bit (offset 2) set. It does not depend on the interrupt enable.
- R8: Offsets 1 to 6 read back the last value written to them. Offset 7 reads the current pin inputs, and writes to offset 7 change no register.
- R9: While rstN is low, every enable register, the status register and the previous-pin register are 0, and irqOut and wakeOut are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| regWr | input | 1 | Write strobe for the register port |
| regAddr | input | 3 | Word offset of the register being read or written |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| pinIn | input | 32 | Synchronized pin levels, one per line |
| irqOut | output | 1 | Bank interrupt request |
| wakeOut | output | 1 | Wakeup request |

## Verification
The bench checks a clear that lands on the same edge as a new edge event. A design that let the clear win would drop that edge silently.

It writes a clear while a level condition still holds. A design that latched level events like edges would lose the bit at that point, even though the source is still asserting it.

It also checks that an edge-sourced bit outlives its pin pulse, that an edge on a line enabled only for the other direction is ignored, and that the two output masks stay independent of each other. It writes to the read-only offset and confirms that no other register changed.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  // Word offsets of the register port; software depends on this layout.
  typedef enum logic [2:0] {
    OFS_STATUS = 3'd0,
    OFS_IRQEN  = 3'd1,
    OFS_WAKEEN = 3'd2,
    OFS_LVLLO  = 3'd3,
    OFS_LVLHI  = 3'd4,
    OFS_RISE   = 3'd5,
    OFS_FALL   = 3'd6,
    OFS_PINS   = 3'd7
  } regOfs_t;

  // Strobes from the decode to the datapath, at most one per cycle.
  typedef struct packed {
    logic clrStatus;
    logic ldIrqEn;
    logic ldWakeEn;
    logic ldLvlLo;
    logic ldLvlHi;
    logic ldRise;
    logic ldFall;
  } regStrobe_t;

endpackage

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [2:0] regAddr,
  output regStrobe_t strb
);

  always_comb begin
    strb = '0;
    if (regWr) begin
      case (regOfs_t'(regAddr))
        OFS_STATUS: strb.clrStatus = 1'b1;
        OFS_IRQEN:  strb.ldIrqEn   = 1'b1;
        OFS_WAKEEN: strb.ldWakeEn  = 1'b1;
        OFS_LVLLO:  strb.ldLvlLo   = 1'b1;
        OFS_LVLHI:  strb.ldLvlHi   = 1'b1;
        OFS_RISE:   strb.ldRise    = 1'b1;
        OFS_FALL:   strb.ldFall    = 1'b1;
        default:    strb = '0;
      endcase
    end
  end

  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R8
  pins_readonly_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd7) |-> (strb == '0));

endmodule

// File: rtl/gpio_evt_datapath.sv
module gpio_evt_datapath
  import gpio_evt_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strb,
  input  logic [LINES-1:0] wdata,
  input  logic [2:0]       rdAddr,
  input  logic [LINES-1:0] pinIn,
  output logic [LINES-1:0] rdata,
  output logic             irqOut,
  output logic             wakeOut
);

  logic [LINES-1:0] statusQ, irqEnQ, wakeEnQ, lvlLoQ, lvlHiQ, riseEnQ, fallEnQ;
  logic [LINES-1:0] pinPrevQ;
  logic [LINES-1:0] evtVec;
  logic [LINES-1:0] clrMask;
  logic [LINES-1:0] statusD;
  logic             clrNow;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnQ  <= '0;
      wakeEnQ <= '0;
      lvlLoQ  <= '0;
      lvlHiQ  <= '0;
      riseEnQ <= '0;
      fallEnQ <= '0;
    end else begin
      if (strb.ldIrqEn)  irqEnQ  <= wdata;
      if (strb.ldWakeEn) wakeEnQ <= wdata;
      if (strb.ldLvlLo)  lvlLoQ  <= wdata;
      if (strb.ldLvlHi)  lvlHiQ  <= wdata;
      if (strb.ldRise)   riseEnQ <= wdata;
      if (strb.ldFall)   fallEnQ <= wdata;
    end
  end

  // Per-line event detection against the value seen on the previous edge
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic roseNow, fellNow;
    assign roseNow   = pinIn[i] & ~pinPrevQ[i];
    assign fellNow   = ~pinIn[i] & pinPrevQ[i];
    assign evtVec[i] = (riseEnQ[i] & roseNow) | (fallEnQ[i] & fellNow)
                     | (lvlHiQ[i] & pinIn[i]) | (lvlLoQ[i] & ~pinIn[i]);
  end

  assign clrNow  = strb.clrStatus;
  assign clrMask = clrNow ? wdata : '0;
  // A fresh event overrides a clear on the same edge
  assign statusD = (statusQ & ~clrMask) | evtVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= '0;
      pinPrevQ <= '0;
    end else begin
      statusQ  <= statusD;
      pinPrevQ <= pinIn;
    end
  end

  always_comb begin
    case (regOfs_t'(rdAddr))
      OFS_STATUS: rdata = statusQ;
      OFS_IRQEN:  rdata = irqEnQ;
      OFS_WAKEEN: rdata = wakeEnQ;
      OFS_LVLLO:  rdata = lvlLoQ;
      OFS_LVLHI:  rdata = lvlHiQ;
      OFS_RISE:   rdata = riseEnQ;
      OFS_FALL:   rdata = fallEnQ;
      default:    rdata = pinIn;
    endcase
  end

  assign irqOut  = |(statusQ & irqEnQ);
  assign wakeOut = |(statusQ & wakeEnQ);

  // R4
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrNow |=> (($past(statusQ) & ~statusQ) == '0));

  // R3
  level_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((((($past(pinIn) & $past(lvlHiQ)) | (~$past(pinIn) & $past(lvlLoQ))))
               & ~statusQ) == '0));

  // R5
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrNow |=> (($past(evtVec) & ~statusQ) == '0));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (irqEnQ != '0));

  // R7
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> (wakeEnQ != '0));

endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
  import gpio_evt_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [2:0]       regAddr,
  input  logic [LINES-1:0] regWdata,
  output logic [LINES-1:0] regRdata,
  input  logic [LINES-1:0] pinIn,
  output logic             irqOut,
  output logic             wakeOut
);

  regStrobe_t strb;

  gpio_evt_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWr   (regWr),
    .regAddr (regAddr),
    .strb    (strb)
  );

  gpio_evt_datapath #(.LINES(LINES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (regWdata),
    .rdAddr  (regAddr),
    .pinIn   (pinIn),
    .rdata   (regRdata),
    .irqOut  (irqOut),
    .wakeOut (wakeOut)
  );

endmodule

// File: tb/gpio_evt_top_test.sv
module gpio_evt_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] pinIn = '0;
  logic        irqOut, wakeOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_evt_top uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pinIn(pinIn),
    .irqOut(irqOut), .wakeOut(wakeOut)
  );

  // Rows: {pin[3:0], clear[3:0], expected status[3:0]}
  // Enables: bit0 rising, bit1 falling, bit2 both edges, bit3 level-high.
  localparam logic [11:0] VEC [12] = '{
    12'b0000_0000_0000,
    12'b0001_0000_0001,  // R1 rise on bit0
    12'b0001_0001_0000,  // R4 clear, no new edge
    12'b0011_0000_0000,  // R2 rise on falling-only bit1 ignored
    12'b0110_0000_0100,  // R2 bit2 rise; R1 bit0 fall ignored
    12'b0010_0100_0100,  // R5 bit2 fall with clear same edge
    12'b0000_0100_0010,  // R2 bit1 fall; bit2 cleared
    12'b1000_0000_1010,  // R3 level-high bit3
    12'b1000_1000_1010,  // R3 clear while high ineffective
    12'b0000_0000_1010,  // R4 latched after level leaves
    12'b0000_1010_0000,  // R4 clear both
    12'b0101_0000_0101   // R1 R2 simultaneous edges
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R9 reset state
    for (int a = 0; a < 7; a++) begin
      readReg(3'(a), rd);
      check("R9 reset reg", rd, 32'h0);
    end
    check("R9 reset irq", {31'b0, irqOut}, 32'h0);
    check("R9 reset wake", {31'b0, wakeOut}, 32'h0);
    rstN = 1'b1;

    writeReg(3'd5, 32'h0000_0005);
    writeReg(3'd6, 32'h0000_0006);
    writeReg(3'd4, 32'h0000_0008);

    for (int s = 0; s < 12; s++) begin
      @(negedge clk);
      pinIn = {28'b0, VEC[s][11:8]};
      if (VEC[s][7:4] != 4'b0) begin
        regWr = 1'b1; regAddr = 3'd0; regWdata = {28'b0, VEC[s][7:4]};
      end
      @(negedge clk);
      regWr = 1'b0;
      readReg(3'd0, rd);
      check($sformatf("table step %0d R1 R2 R3 R4 R5", s), rd, {28'b0, VEC[s][3:0]});
    end

    // R3 level-low on bit4 (pin low now)
    writeReg(3'd3, 32'h0000_0010);
    @(negedge clk);
    readReg(3'd0, rd);
    check("R3 level-low sets", rd, 32'h0000_0015);
    writeReg(3'd0, 32'h0000_0010);
    readReg(3'd0, rd);
    check("R3 clear while low kept", rd, 32'h0000_0015);
    pinIn[4] = 1'b1;
    @(negedge clk);
    readReg(3'd0, rd);
    check("R4 level status latched", rd, 32'h0000_0015);
    writeReg(3'd0, 32'h0000_0010);
    readReg(3'd0, rd);
    check("R4 level bit cleared", rd, 32'h0000_0005);

    // R6 / R7 masks; status = bits 0 and 2
    check("R6 irq masked off", {31'b0, irqOut}, 32'h0);
    writeReg(3'd1, 32'h0000_0008);
    check("R6 irq unrelated line", {31'b0, irqOut}, 32'h0);
    writeReg(3'd1, 32'h0000_0004);
    check("R6 irq enabled line", {31'b0, irqOut}, 32'h1);
    check("R7 wake off with irq on", {31'b0, wakeOut}, 32'h0);
    writeReg(3'd1, 32'h0);
    writeReg(3'd2, 32'h0000_0001);
    check("R7 wake on", {31'b0, wakeOut}, 32'h1);
    check("R6 irq off with wake on", {31'b0, irqOut}, 32'h0);

    // R8 readback and read-only offset
    writeReg(3'd1, 32'hA5A5_0000);
    readReg(3'd1, rd);
    check("R8 irqen readback", rd, 32'hA5A5_0000);
    readReg(3'd6, rd);
    check("R8 fall readback", rd, 32'h0000_0006);
    pinIn = 32'h1234_5670;
    writeReg(3'd7, 32'hFFFF_FFFF);
    readReg(3'd7, rd);
    check("R8 pins read", rd, 32'h1234_5670);
    readReg(3'd1, rd);
    check("R8 write to pins ignored", rd, 32'hA5A5_0000);
    readReg(3'd3, rd);
    check("R8 write to pins ignored lvlLo", rd, 32'h0000_0010);

    // R9 reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    readReg(3'd0, rd);
    check("R9 status after reset", rd, 32'h0);
    readReg(3'd2, rd);
    check("R9 wakeen after reset", rd, 32'h0);
    check("R9 wake after reset", {31'b0, wakeOut}, 32'h0);
    rstN = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule